// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block steers a 32-bit processor that executes each instruction over several clock cycles, sharing one memory for instructions and data and a single ALU for every arithmetic step. It is a Moore state machine: the register write enables, the datapath multiplexer selects and a two-bit ALU operation class depend only on the current state. The opcode field of the instruction register and the ALU zero flag are its only data inputs. The block also forms the program-counter load enable from the unconditional PC write and from a branch that is taken.

Every instruction starts in FETCH. FETCH always moves to DECODE, which picks the execution path from the opcode. Loads run FETCH, DECODE, ADDR, MEM_READ, MEM_WB. Stores run FETCH, DECODE, ADDR, MEM_WRITE. Register-register ALU operations run FETCH, DECODE, EXEC, EXEC_WB. Add-immediate runs FETCH, DECODE, IMM_EXEC, IMM_WB. Branch-if-equal runs FETCH, DECODE, BRANCH. Jump runs FETCH, DECODE, JUMP. Each final state returns to FETCH. An opcode with no path sends DECODE back to FETCH. DECODE sets the ALU to add PC+4 and the shifted immediate, so the branch target is ready before BRANCH.

Top module: `multicycle_ctrl`

## Requirements
- R1: A clock edge with `rst` high puts the block in FETCH. FETCH drives `pc_wr`=1, `ir_wr`=1, `alu_b_sel`=01, and all other selects and `alu_mode`=00.
- R2: FETCH always moves to DECODE on the next edge, whatever the opcode.
- R3: DECODE drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_mode`=00. It moves to ADDR for load (100011) or store (101011), EXEC for register-register (000000), BRANCH for branch-if-equal (000100), IMM_EXEC for add-immediate (001000) and JUMP for jump (000010).
- R4: Any other opcode in DECODE returns the block to FETCH on the next edge.
- R5: ADDR drives `alu_a_sel`=1, `alu_b_sel`=10 and `alu_mode`=00. It moves to MEM_READ for a load opcode and to MEM_WRITE otherwise.
- R6: MEM_READ drives `addr_sel`=1 and moves to MEM_WB. MEM_WB asserts `rf_wr` with `rf_dst_sel`=0 and `rf_wdata_sel`=1.
- R7: MEM_WRITE drives `addr_sel`=1 and asserts `mem_wr`.
- R8: EXEC drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_mode`=10, then moves to EXEC_WB. EXEC_WB asserts `rf_wr` with `rf_dst_sel`=1 and `rf_wdata_sel`=0.
- R9: BRANCH drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01 and `pc_next_sel`=01, and asserts `br_en`.
- R10: IMM_EXEC drives `alu_a_sel`=1, `alu_b_sel`=10 and `alu_mode`=00, then moves to IMM_WB. IMM_WB asserts `rf_wr` with `rf_dst_sel`=0 and `rf_wdata_sel`=0.
- R11: JUMP drives `pc_next_sel`=10 and asserts `pc_wr`.
- R12: `pc_en` is high exactly when `pc_wr` is high or when both `br_en` and `alu_zero` are high.
- R13: MEM_WB, MEM_WRITE, EXEC_WB, BRANCH, IMM_WB and JUMP return to FETCH on the next edge. Fetch to the next fetch takes 3 cycles for branch and jump, 4 for register-register, store and add-immediate, 5 for load, and 2 for an opcode with no path.
- R14: In every state, each enable and each select that the requirement for that state does not name is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the current instruction |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_wr | output | 1 | Unconditional program-counter write |
| ir_wr | output | 1 | Instruction register load |
| rf_wr | output | 1 | Register file write |
| mem_wr | output | 1 | Shared memory write |
| br_en | output | 1 | Conditional branch in progress |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 ALU result register |
| alu_a_sel | output | 1 | ALU A source: 0 PC, 1 register operand |
| alu_b_sel | output | 2 | ALU B source: 00 register, 01 constant 4, 10 immediate, 11 shifted immediate |
| pc_next_sel | output | 2 | Next PC: 00 ALU result, 01 held ALU result, 10 jump target |
| rf_dst_sel | output | 1 | Destination field: 0 second source field, 1 destination field |
| rf_wdata_sel | output | 1 | Write-back source: 0 ALU result, 1 memory data |
| alu_mode | output | 2 | ALU class: 00 add, 01 subtract, 10 by function field |
| pc_en | output | 1 | Program-counter load enable |

## Verification
The bench builds the block with the default 6-bit opcode and the default opcode codes. With only 64 opcode values, a full sweep through DECODE is possible, so every undefined code is shown to return to FETCH, and each defined path is reached. After the sweep, random instruction mixes with a random zero flag check `pc_en` in BRANCH both taken and not taken. A reset in the middle of an instruction checks that the block returns to FETCH from any point in a sequence.

// File: rtl/mcctl_pkg.sv
package mcctl_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH     = 4'd0,
        ST_DECODE    = 4'd1,
        ST_ADDR      = 4'd2,
        ST_MEM_READ  = 4'd3,
        ST_MEM_WB    = 4'd4,
        ST_MEM_WRITE = 4'd5,
        ST_EXEC      = 4'd6,
        ST_EXEC_WB   = 4'd7,
        ST_BRANCH    = 4'd8,
        ST_IMM_EXEC  = 4'd9,
        ST_IMM_WB    = 4'd10,
        ST_JUMP      = 4'd11
    } state_e;

    typedef struct packed {
        logic       pc_wr;
        logic       ir_wr;
        logic       rf_wr;
        logic       mem_wr;
        logic       br_en;
        logic       addr_sel;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] pc_next_sel;
        logic       rf_dst_sel;
        logic       rf_wdata_sel;
        logic [1:0] alu_mode;
    } ctrl_s;

endpackage

// File: rtl/mcctl_seq.sv
module mcctl_seq
    import mcctl_pkg::*;
#(
    parameter int              OPC_W    = 6,
    parameter logic [OPC_W-1:0] OPC_LOAD  = 6'b100011,
    parameter logic [OPC_W-1:0] OPC_STORE = 6'b101011,
    parameter logic [OPC_W-1:0] OPC_RTYPE = 6'b000000,
    parameter logic [OPC_W-1:0] OPC_BEQ   = 6'b000100,
    parameter logic [OPC_W-1:0] OPC_ADDI  = 6'b001000,
    parameter logic [OPC_W-1:0] OPC_JUMP  = 6'b000010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output state_e           state_q
);

    state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = ST_FETCH;
        unique case (state_q)
            ST_FETCH:    state_d = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OPC_LOAD || opcode == OPC_STORE) state_d = ST_ADDR;
                else if (opcode == OPC_RTYPE) state_d = ST_EXEC;
                else if (opcode == OPC_BEQ)   state_d = ST_BRANCH;
                else if (opcode == OPC_ADDI)  state_d = ST_IMM_EXEC;
                else if (opcode == OPC_JUMP)  state_d = ST_JUMP;
                else                          state_d = ST_FETCH;
            end
            ST_ADDR:     state_d = (opcode == OPC_LOAD) ? ST_MEM_READ : ST_MEM_WRITE;
            ST_MEM_READ: state_d = ST_MEM_WB;
            ST_EXEC:     state_d = ST_EXEC_WB;
            ST_IMM_EXEC: state_d = ST_IMM_WB;
            ST_MEM_WB, ST_MEM_WRITE, ST_EXEC_WB,
            ST_BRANCH, ST_IMM_WB, ST_JUMP:
                         state_d = ST_FETCH;
            default:     state_d = ST_FETCH;
        endcase
    end

    AST_RESET_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == ST_FETCH)); // R1

    AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE)); // R2

endmodule

// File: rtl/mcctl_outdec.sv
module mcctl_outdec
    import mcctl_pkg::*;
(
    input  state_e state,
    output ctrl_s  ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (state)
            ST_FETCH: begin
                ctrl.pc_wr     = 1'b1;
                ctrl.ir_wr     = 1'b1;
                ctrl.alu_b_sel = 2'b01;
            end
            ST_DECODE: begin
                ctrl.alu_b_sel = 2'b11;
            end
            ST_ADDR, ST_IMM_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = 2'b10;
            end
            ST_MEM_READ: begin
                ctrl.addr_sel = 1'b1;
            end
            ST_MEM_WB: begin
                ctrl.rf_wr        = 1'b1;
                ctrl.rf_wdata_sel = 1'b1;
            end
            ST_MEM_WRITE: begin
                ctrl.addr_sel = 1'b1;
                ctrl.mem_wr   = 1'b1;
            end
            ST_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_mode  = 2'b10;
            end
            ST_EXEC_WB: begin
                ctrl.rf_wr      = 1'b1;
                ctrl.rf_dst_sel = 1'b1;
            end
            ST_BRANCH: begin
                ctrl.alu_a_sel   = 1'b1;
                ctrl.alu_mode    = 2'b01;
                ctrl.pc_next_sel = 2'b01;
                ctrl.br_en       = 1'b1;
            end
            ST_IMM_WB: begin
                ctrl.rf_wr = 1'b1;
            end
            ST_JUMP: begin
                ctrl.pc_next_sel = 2'b10;
                ctrl.pc_wr       = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

    always_comb begin
        AST_WRITERS_EXCLUSIVE: assert ($onehot0({ctrl.rf_wr, ctrl.mem_wr, ctrl.br_en, ctrl.ir_wr})); // R14
    end

endmodule

// File: rtl/multicycle_ctrl.sv
module multicycle_ctrl
    import mcctl_pkg::*;
#(
    parameter int              OPC_W    = 6,
    parameter logic [OPC_W-1:0] OPC_LOAD  = 6'b100011,
    parameter logic [OPC_W-1:0] OPC_STORE = 6'b101011,
    parameter logic [OPC_W-1:0] OPC_RTYPE = 6'b000000,
    parameter logic [OPC_W-1:0] OPC_BEQ   = 6'b000100,
    parameter logic [OPC_W-1:0] OPC_ADDI  = 6'b001000,
    parameter logic [OPC_W-1:0] OPC_JUMP  = 6'b000010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_zero,
    output logic             pc_wr,
    output logic             ir_wr,
    output logic             rf_wr,
    output logic             mem_wr,
    output logic             br_en,
    output logic             addr_sel,
    output logic             alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic [1:0]       pc_next_sel,
    output logic             rf_dst_sel,
    output logic             rf_wdata_sel,
    output logic [1:0]       alu_mode,
    output logic             pc_en
);

    state_e cur_state;
    ctrl_s  ctrl;

    mcctl_seq #(
        .OPC_W    (OPC_W),
        .OPC_LOAD (OPC_LOAD),
        .OPC_STORE(OPC_STORE),
        .OPC_RTYPE(OPC_RTYPE),
        .OPC_BEQ  (OPC_BEQ),
        .OPC_ADDI (OPC_ADDI),
        .OPC_JUMP (OPC_JUMP)
    ) seq_i (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .state_q(cur_state)
    );

    mcctl_outdec outdec_i (
        .state(cur_state),
        .ctrl (ctrl)
    );

    assign pc_wr        = ctrl.pc_wr;
    assign ir_wr        = ctrl.ir_wr;
    assign rf_wr        = ctrl.rf_wr;
    assign mem_wr       = ctrl.mem_wr;
    assign br_en        = ctrl.br_en;
    assign addr_sel     = ctrl.addr_sel;
    assign alu_a_sel    = ctrl.alu_a_sel;
    assign alu_b_sel    = ctrl.alu_b_sel;
    assign pc_next_sel  = ctrl.pc_next_sel;
    assign rf_dst_sel   = ctrl.rf_dst_sel;
    assign rf_wdata_sel = ctrl.rf_wdata_sel;
    assign alu_mode     = ctrl.alu_mode;

    // Taken branch or unconditional write loads the program counter
    assign pc_en = ctrl.pc_wr | (ctrl.br_en & alu_zero);

    AST_TAKEN_BRANCH_LOADS_PC: assert property (@(posedge clk) disable iff (rst)
        (br_en && alu_zero) |-> pc_en); // R12

    AST_LAST_STEP_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (mem_wr || rf_wr || br_en || (pc_wr && !ir_wr)) |=> ir_wr); // R13

    AST_READ_THEN_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        (addr_sel && !mem_wr) |=> (rf_wr && rf_wdata_sel && !rf_dst_sel)); // R6

    AST_DECODE_PREPS_TARGET: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (alu_b_sel == 2'b11 && !alu_a_sel && !ir_wr)); // R3

endmodule

// File: tb/multicycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module multicycle_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       alu_zero = 1'b0;
    logic pc_wr, ir_wr, rf_wr, mem_wr, br_en, addr_sel, alu_a_sel;
    logic [1:0] alu_b_sel, pc_next_sel, alu_mode;
    logic rf_dst_sel, rf_wdata_sel, pc_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    multicycle_ctrl dut_i (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
        .pc_wr(pc_wr), .ir_wr(ir_wr), .rf_wr(rf_wr), .mem_wr(mem_wr),
        .br_en(br_en), .addr_sel(addr_sel), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .pc_next_sel(pc_next_sel),
        .rf_dst_sel(rf_dst_sel), .rf_wdata_sel(rf_wdata_sel),
        .alu_mode(alu_mode), .pc_en(pc_en)
    );

    localparam logic [5:0] C_LD = 6'b100011, C_ST = 6'b101011, C_RR = 6'b000000,
                           C_BQ = 6'b000100, C_AI = 6'b001000, C_JP = 6'b000010;

    // Model: integer step number, expected enables {pc_wr,ir_wr,rf_wr,mem_wr,br_en}
    // and selects {addr,a,b[2],pc[2],dst,wdata,mode[2]}
    function automatic logic [4:0] exp_en(int s);
        case (s)
            0: return 5'b11000;
            4, 7, 10: return 5'b00100;
            5: return 5'b00010;
            8: return 5'b00001;
            11: return 5'b10000;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic logic [10:0] exp_sel(int s);
        case (s)
            0: return 11'b0_0_01_00_0_0_00;
            1: return 11'b0_0_11_00_0_0_00;
            2, 9: return 11'b0_1_10_00_0_0_00;
            3, 5: return 11'b1_0_00_00_0_0_00;
            4: return 11'b0_0_00_00_0_1_00;
            6: return 11'b0_1_00_00_0_0_10;
            7: return 11'b0_0_00_00_1_0_00;
            8: return 11'b0_1_00_01_0_0_01;
            11: return 11'b0_0_00_10_0_0_00;
            default: return 11'b0;
        endcase
    endfunction

    function automatic int next_step(int s, logic [5:0] op);
        case (s)
            0: return 1;
            1: begin
                if (op == C_LD || op == C_ST) return 2;
                if (op == C_RR) return 6;
                if (op == C_BQ) return 8;
                if (op == C_AI) return 9;
                if (op == C_JP) return 11;
                return 0;
            end
            2: return (op == C_LD) ? 3 : 5;
            3: return 4;
            6: return 7;
            9: return 10;
            default: return 0;
        endcase
    endfunction

    function automatic int instr_len(logic [5:0] op);
        if (op == C_LD) return 5;
        if (op == C_ST || op == C_RR || op == C_AI) return 4;
        if (op == C_BQ || op == C_JP) return 3;
        return 2;
    endfunction

    function automatic string tag_of(int s, int prev);
        if (s == 0 && prev == 1) return "R4";
        case (s)
            0: return "R1";
            1: return "R2 R3";
            2: return "R5";
            3, 4: return "R6";
            5: return "R7";
            6, 7: return "R8";
            8: return "R9";
            9, 10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    int mstate = 0;
    int mprev = 0;
    int since_fetch = -1;
    logic [5:0] cur_op = 6'd0;

    task automatic compare_now();
        logic [4:0] en_act;
        logic [10:0] sel_act;
        en_act  = {pc_wr, ir_wr, rf_wr, mem_wr, br_en};
        sel_act = {addr_sel, alu_a_sel, alu_b_sel, pc_next_sel, rf_dst_sel, rf_wdata_sel, alu_mode};
        check(tag_of(mstate, mprev), {5'd0, sel_act}, {5'd0, exp_sel(mstate)});
        check({tag_of(mstate, mprev), " R14"}, {11'd0, en_act}, {11'd0, exp_en(mstate)});
        check("R12", {15'd0, pc_en},
              {15'd0, exp_en(mstate)[4] | (exp_en(mstate)[0] & alu_zero)});
    endtask

    task automatic step(bit do_rst, logic [5:0] op_new, bit new_instr);
        // Called at a negedge: compare, then drive inputs for the coming edge
        compare_now();
        if (mstate == 0 && !do_rst) begin
            if (since_fetch >= 0)
                check("R13", 16'(since_fetch), 16'(instr_len(cur_op)));
            since_fetch = 0;
            if (new_instr) cur_op = op_new;
        end
        since_fetch++;
        opcode   = cur_op;
        alu_zero = 1'($urandom_range(0, 1));
        rst      = do_rst;
        mprev    = mstate;
        mstate   = do_rst ? 0 : next_step(mstate, cur_op);
        if (do_rst) since_fetch = -1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state (R1)
        compare_now();
        rst = 1'b0;
        mstate = 0;
        // Sweep all 64 opcodes, one instruction each
        for (int op = 0; op < 64; op++) begin
            step(1'b0, 6'(op), 1'b1);
            while (mstate != 0) step(1'b0, 6'(op), 1'b0);
        end
        // Random mix weighted toward defined codes
        for (int n = 0; n < 300; n++) begin
            logic [5:0] pick;
            case ($urandom_range(0, 6))
                0: pick = C_LD; 1: pick = C_ST; 2: pick = C_RR;
                3: pick = C_BQ; 4: pick = C_AI; 5: pick = C_JP;
                default: pick = 6'($urandom_range(0, 63));
            endcase
            step(1'b0, pick, 1'b1);
            while (mstate != 0) step(1'b0, pick, 1'b0);
            if (n == 150) begin
                // Reset in the middle of a load (R1)
                step(1'b0, C_LD, 1'b1);
                step(1'b0, C_LD, 1'b0);
                step(1'b0, C_LD, 1'b0);
                step(1'b1, C_LD, 1'b0);
                step(1'b0, C_LD, 1'b1);
                while (mstate != 0) step(1'b0, C_LD, 1'b0);
            end
        end
        compare_now();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule